// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter that software sees as two byte registers. It has two count sources. The first is an internal tick that fires once every four system clocks. The second is the rising edges on one of two external pins. A 2-bit ratio field places a divide-by-1, 2, 4 or 8 prescaler in front of the counter. When the counter wraps from 0xFFFF to 0x0000, a sticky overflow flag is set. The flag stays set until software clears it.

External edges are sampled into the system clock domain. A small arming state machine ignores rising edges until it has seen a falling edge since the counter was enabled. The prescaler counts these raw qualified edges. Its output pulse then passes through a two-stage synchronizer before it reaches the counter. Software can bypass that synchronizer to cut one cycle of latency. While the synchronizer is in use, a sleep input blocks counter increments, but the prescaler keeps counting.

The arming machine has three states:
- ARM_OFF: counting from the pin is disabled.
- ARM_WAIT_FALL: enabled, waiting for the first falling edge.
- ARM_LIVE: rising edges are counted.

Its transitions are:
- ARM_OFF to ARM_WAIT_FALL when run and external mode are both set.
- ARM_WAIT_FALL to ARM_LIVE on a sampled falling edge.
- ARM_WAIT_FALL or ARM_LIVE back to ARM_OFF when run or external mode is cleared.

Top module: `tc16_timer`

## Requirements
- R1: After reset, the control register, both counter bytes and the overflow flag all read 0.
- R2: With the source bit (control bit 1) at 0 and run (control bit 0) at 1, the counter advances once every 4×ratio clocks. The first increment lands on the 4×ratio-th clock edge after the write that set run. The bypass bit (control bit 2) has no effect in this mode.
- R3: The ratio field (control bits 5:4) selects the prescaler: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: With the source bit at 1, rising edges on the selected pin are counted. The pin-select bit (control bit 3) picks pin_a_i when it is 1 and pin_b_i when it is 0. The pin that is not selected has no effect.
- R5: After counting is enabled in external mode, no rising edge is counted until a falling edge has been seen on the selected pin.
- R6: At ratio 1, the counter shows a rising edge on the pin 4 clock edges after the pin changes when the bypass bit is 0, and 3 edges after when the bypass bit is 1.
- R7: In external mode with the bypass bit at 0, sleep_i blocks counter increments but the prescaler keeps counting edges. With the bypass bit at 1, sleep_i has no effect.
- R8: A wrap from 0xFFFF to 0x0000 sets the overflow flag (status address 3, bit 0, also on ovf_o). Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged.
- R9: A write to address 1 loads the low byte and a write to address 2 loads the high byte. A write takes priority over an increment in the same cycle. A write to either counter byte or to the control register clears the prescaler and the divide-by-four phase.
- R10: Clearing run freezes the counter. Setting run again in external mode re-arms the falling-edge requirement.
- R11: Address 0 reads back the 6 control bits in bits 5:0, with bits 7:6 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep request; gates synchronized external counting |
| pin_a_i | input | 1 | External clock pin used when pin-select is 1 |
| pin_b_i | input | 1 | External clock pin used when pin-select is 0 |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 low byte, 2 high byte, 3 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A wrong divide-by-four phase or prescaler count shows at the ports as an increment that arrives early or late. The bench catches this within one period of 4×ratio clocks, because it samples the counter one edge before and one edge at the expected increment. If the arming machine were stuck in the wrong state, the count after the first pin pulse would be off by one, so the error appears within a single pulse of about six clocks. A synchronizer depth that is wrong, or bypassed when it should not be, changes the exact edge on which the counter moves. The latency checks sample at edges 2, 3 and 4 after the pin changes to catch this. A sleep gate placed before the prescaler instead of after it would leave the count one short on the pulse after wake-up.

// File: rtl/tc16_pkg.sv
package tc16_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int PHASE_W   = 2;
    localparam int PS_SEL_W  = 2;
    localparam int PS_CNT_W  = (1 << PS_SEL_W) - 1;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LO   = 2'd1,
        REG_HI   = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PS_SEL_W-1:0] ratio;
        logic                pin_sel;
        logic                bypass;
        logic                src_ext;
        logic                run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ARM_OFF       = 2'd0,
        ARM_WAIT_FALL = 2'd1,
        ARM_LIVE      = 2'd2
    } arm_state_e;

endpackage

// File: rtl/tc16_edge_arm.sv
module tc16_edge_arm
    import tc16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pin,
    output logic tick_o
);

    logic       cap_q;
    logic       prev_q;
    logic       rise;
    logic       fall;
    arm_state_e state_q;
    arm_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cap_q  <= pin;
            prev_q <= cap_q;
        end
    end

    assign rise = cap_q & ~prev_q;
    assign fall = ~cap_q & prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ARM_OFF: begin
                if (enable) state_nxt = ARM_WAIT_FALL;
            end
            ARM_WAIT_FALL: begin
                if (!enable)   state_nxt = ARM_OFF;
                else if (fall) state_nxt = ARM_LIVE;
            end
            ARM_LIVE: begin
                if (!enable) state_nxt = ARM_OFF;
            end
            default: state_nxt = ARM_OFF;
        endcase
    end

    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            ARM_LIVE: tick_o = rise & enable;
            default:  tick_o = 1'b0;
        endcase
    end

    // R5: the live state is only reachable through the wait state
    assert_live_via_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_LIVE) |-> ($past(state_q) != ARM_OFF));

    // R10: dropping enable always returns to the off state
    assert_drop_to_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (state_q == ARM_OFF));

endmodule

// File: rtl/tc16_prescale.sv
module tc16_prescale #(
    parameter int SEL_W = 2,
    parameter int CNT_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             out_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    assign mask  = CNT_W'((1 << sel) - 1);
    assign out_o = tick && (cnt_q == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == mask) cnt_q <= '0;
            else               cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3: the divider count never passes the selected ratio
    assert_count_in_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= mask);

endmodule

// File: rtl/tc16_sync_chain.sv
module tc16_sync_chain #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             d,
    output logic [DEPTH-1:0] taps
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic src;
        if (i == 0) begin : g_first
            assign src = d;
        end else begin : g_rest
            assign src = taps[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   taps[i] <= 1'b0;
            else if (clr) taps[i] <= 1'b0;
            else          taps[i] <= src;
        end
    end

endmodule

// File: rtl/tc16_timer.sv
module tc16_timer
    import tc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              pin_a_i,
    input  logic              pin_b_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              ovf_o
);

    ctrl_t               ctrl_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                ovf_q;
    logic [PHASE_W-1:0]  phase_q;
    reg_sel_e            sel;
    logic                wr_ctrl, wr_lo, wr_hi, wr_stat, wr_cnt, wr_cfg;
    logic                run_int, run_ext;
    logic                int_tick, arm_tick, pre_tick, pre_out;
    logic                ext_pin;
    logic [SYNC_DEPTH-1:0] sync_taps;
    logic                inc_int, inc_ext, inc;

    assign sel     = reg_sel_e'(bus_addr_i);
    assign wr_ctrl = bus_we_i && (sel == REG_CTRL);
    assign wr_lo   = bus_we_i && (sel == REG_LO);
    assign wr_hi   = bus_we_i && (sel == REG_HI);
    assign wr_stat = bus_we_i && (sel == REG_STAT);
    assign wr_cnt  = wr_lo | wr_hi;
    assign wr_cfg  = wr_cnt | wr_ctrl;

    assign run_int = ctrl_q.run & ~ctrl_q.src_ext;
    assign run_ext = ctrl_q.run &  ctrl_q.src_ext;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
    end

    // divide-by-four phase for the internal source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  phase_q <= '0;
        else if (wr_cfg || !run_int) phase_q <= '0;
        else                         phase_q <= phase_q + PHASE_W'(1);
    end
    assign int_tick = run_int && (phase_q == {PHASE_W{1'b1}});

    // external pin path
    assign ext_pin = ctrl_q.pin_sel ? pin_a_i : pin_b_i;

    tc16_edge_arm u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (run_ext),
        .pin    (ext_pin),
        .tick_o (arm_tick)
    );

    assign pre_tick = ctrl_q.src_ext ? arm_tick : int_tick;

    tc16_prescale #(
        .SEL_W (PS_SEL_W),
        .CNT_W (PS_CNT_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_cfg | ~ctrl_q.run),
        .tick  (pre_tick),
        .sel   (ctrl_q.ratio),
        .out_o (pre_out)
    );

    tc16_sync_chain #(
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~run_ext),
        .d     (pre_out & run_ext),
        .taps  (sync_taps)
    );

    assign inc_int = run_int & pre_out;
    assign inc_ext = run_ext & (ctrl_q.bypass ? sync_taps[0]
                                              : (sync_taps[SYNC_DEPTH-1] & ~sleep_i));
    assign inc     = inc_int | inc_ext;

    // counter halves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            if (wr_lo) cnt_q[BYTE_W-1:0]     <= bus_wdata_i;
            if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= bus_wdata_i;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ovf_q <= 1'b0;
        else if (inc && !wr_cnt && (&cnt_q))     ovf_q <= 1'b1;
        else if (wr_stat && !bus_wdata_i[0])     ovf_q <= 1'b0;
    end
    assign ovf_o = ovf_q;

    always_comb begin
        unique case (sel)
            REG_CTRL: bus_rdata_o = BYTE_W'(ctrl_q);
            REG_LO:   bus_rdata_o = cnt_q[BYTE_W-1:0];
            REG_HI:   bus_rdata_o = cnt_q[CNT_W-1:BYTE_W];
            REG_STAT: bus_rdata_o = BYTE_W'(ovf_q);
        endcase
    end

    // R2: the counter moves by at most one per clock unless written
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R10: a stopped counter holds its value
    assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_cnt) |=> $stable(cnt_q));

    // R7: synchronized external counting stalls while asleep
    assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ext && !ctrl_q.bypass && sleep_i && !wr_cnt) |=> $stable(cnt_q));

    // R8: a wrap raises the flag
    assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && (&cnt_q)) ##1 (cnt_q == '0) |-> ovf_q);

    // R8: the flag only drops on a zero write to status
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_stat && !bus_wdata_i[0])) |=> ovf_q);

endmodule

// File: tb/test_tc16_timer.sv
module test_tc16_timer;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LO   = 2'd1;
    localparam logic [1:0] A_HI   = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;
    localparam logic [7:0] C_RUN  = 8'h01;
    localparam logic [7:0] C_EXT  = 8'h02;
    localparam logic [7:0] C_BYP  = 8'h04;
    localparam logic [7:0] C_PINA = 8'h08;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       pin_a_i = 1'b0;
    logic       pin_b_i = 1'b0;
    logic       bus_we_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic [7:0] bus_wdata_i = 8'd0;
    logic [7:0] bus_rdata_o;
    logic       ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tc16_timer i_tc16_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_i     (sleep_i),
        .pin_a_i     (pin_a_i),
        .pin_b_i     (pin_b_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .ovf_o       (ovf_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr_i = a;
        #1;
        v = int'(bus_rdata_o);
    endtask

    task automatic rd_cnt(output int v);
        int lo, hi;
        rd(A_LO, lo);
        rd(A_HI, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic zero();
        wr(A_CTRL, 8'h00); wr(A_LO, 8'h00); wr(A_HI, 8'h00);
    endtask

    task automatic pulse(input bit use_a);
        if (use_a) pin_a_i = 1'b1; else pin_b_i = 1'b1;
        step(3);
        if (use_a) pin_a_i = 1'b0; else pin_b_i = 1'b0;
        step(3);
    endtask

    task automatic t_reset();
        int v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd_cnt(v);     chk("R1 count", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        chk("R1 ovf_o", int'(ovf_o), 0);
    endtask

    task automatic t_internal();
        int v;
        for (int ps = 0; ps < 4; ps++) begin
            int n;
            n = 4 * (1 << ps);
            zero();
            wr(A_CTRL, C_RUN | 8'(ps << 4));
            step(n - 1); rd_cnt(v); chk("R2 before first increment", v, 0);
            step(1);     rd_cnt(v); chk("R3 first increment at ratio", v, 1);
            step(2 * n); rd_cnt(v); chk("R3 steady rate", v, 3);
        end
        zero();
        wr(A_CTRL, C_RUN | C_BYP | 8'h10);
        step(7); rd_cnt(v); chk("R2 bypass ignored early", v, 0);
        step(1); rd_cnt(v); chk("R2 bypass ignored", v, 1);
    endtask

    task automatic t_pin_select();
        int v;
        zero();
        wr(A_CTRL, C_RUN | C_EXT | C_BYP);
        step(2);
        pulse(1'b0);
        pulse(1'b1); pulse(1'b1);
        rd_cnt(v); chk("R4 unselected pin a ignored", v, 0);
        pulse(1'b0); pulse(1'b0);
        rd_cnt(v); chk("R4 pin b counted", v, 2);
        wr(A_CTRL, C_RUN | C_EXT | C_BYP | C_PINA);
        pulse(1'b1);
        rd_cnt(v); chk("R4 pin a counted", v, 3);
        pulse(1'b0);
        rd_cnt(v); chk("R4 unselected pin b ignored", v, 3);
    endtask

    task automatic t_arm();
        int v;
        zero();
        wr(A_CTRL, C_RUN | C_EXT | C_PINA);
        step(2);
        pulse(1'b1);
        rd_cnt(v); chk("R5 rise before fall ignored", v, 0);
        pulse(1'b1);
        rd_cnt(v); chk("R5 counted after fall", v, 1);
        zero();
        pin_a_i = 1'b1;
        step(2);
        wr(A_CTRL, C_RUN | C_EXT | C_PINA);
        step(3);
        pin_a_i = 1'b0;
        step(3);
        rd_cnt(v); chk("R5 fall alone no count", v, 0);
        pulse(1'b1);
        rd_cnt(v); chk("R5 first rise after fall", v, 1);
    endtask

    task automatic t_latency();
        int v;
        for (int byp = 1; byp >= 0; byp--) begin
            zero();
            wr(A_CTRL, C_RUN | C_EXT | C_PINA | (byp != 0 ? C_BYP : 8'h00));
            step(2);
            pulse(1'b1);
            pin_a_i = 1'b1;
            step(2); rd_cnt(v); chk("R6 edge 2", v, 0);
            step(1); rd_cnt(v); chk("R6 edge 3", v, byp);
            step(1); rd_cnt(v); chk("R6 edge 4", v, 1);
            pin_a_i = 1'b0;
            step(3);
        end
    endtask

    task automatic t_sleep();
        int v;
        zero();
        wr(A_CTRL, C_RUN | C_EXT | C_PINA | 8'h10);
        step(2);
        pulse(1'b1);
        sleep_i = 1'b1;
        pulse(1'b1); pulse(1'b1);
        rd_cnt(v); chk("R7 sleep blocks counter", v, 0);
        pulse(1'b1);
        rd_cnt(v); chk("R7 still blocked", v, 0);
        sleep_i = 1'b0;
        pulse(1'b1);
        rd_cnt(v); chk("R7 prescaler kept counting in sleep", v, 1);
        zero();
        wr(A_CTRL, C_RUN | C_EXT | C_PINA | C_BYP);
        step(2);
        pulse(1'b1);
        sleep_i = 1'b1;
        pulse(1'b1);
        rd_cnt(v); chk("R7 bypass ignores sleep", v, 1);
        sleep_i = 1'b0;
    endtask

    task automatic t_overflow();
        int v;
        wr(A_CTRL, 8'h00);
        wr(A_LO, 8'hFF); wr(A_HI, 8'hFF);
        rd_cnt(v); chk("R9 byte loads", v, 16'hFFFF);
        wr(A_CTRL, C_RUN);
        step(3); rd(A_STAT, v); chk("R8 flag before wrap", v, 0);
        step(1); rd_cnt(v);     chk("R8 wrap to zero", v, 0);
        rd(A_STAT, v);          chk("R8 flag set", v, 1);
        chk("R8 ovf_o set", int'(ovf_o), 1);
        step(8); rd(A_STAT, v); chk("R8 flag sticky", v, 1);
        wr(A_STAT, 8'h01); rd(A_STAT, v); chk("R8 write one keeps flag", v, 1);
        wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R8 write zero clears", v, 0);
        chk("R8 ovf_o cleared", int'(ovf_o), 0);
    endtask

    task automatic t_write();
        int v;
        zero();
        wr(A_HI, 8'h12); wr(A_LO, 8'h34);
        rd_cnt(v); chk("R9 readback", v, 16'h1234);
        wr(A_CTRL, C_RUN | 8'h30);
        rd(A_CTRL, v); chk("R11 control readback", v, 8'h31);
        step(20);
        wr(A_LO, 8'h40);
        step(31); rd_cnt(v); chk("R9 prescaler cleared by write", v, 16'h1240);
        step(1);  rd_cnt(v); chk("R9 increment after full period", v, 16'h1241);
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, v); chk("R11 upper control bits read zero", v, 8'h3F);
    endtask

    task automatic t_freeze();
        int v;
        zero();
        wr(A_CTRL, C_RUN);
        step(8); rd_cnt(v); chk("R10 running", v, 2);
        wr(A_CTRL, 8'h00);
        step(12); rd_cnt(v); chk("R10 frozen", v, 2);
        wr(A_CTRL, C_RUN | C_EXT | C_PINA);
        step(2);
        pulse(1'b1); pulse(1'b1);
        rd_cnt(v); chk("R10 external live", v, 3);
        wr(A_CTRL, C_EXT | C_PINA);
        pulse(1'b1);
        rd_cnt(v); chk("R10 external frozen", v, 3);
        wr(A_CTRL, C_RUN | C_EXT | C_PINA);
        step(2);
        pulse(1'b1);
        rd_cnt(v); chk("R10 re-armed", v, 3);
        pulse(1'b1);
        rd_cnt(v); chk("R10 counting after re-arm", v, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_internal();
        t_pin_select();
        t_arm();
        t_latency();
        t_sleep();
        t_overflow();
        t_write();
        t_freeze();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule